// File: doc/BRIEF.md
# Command Ring Processor

This block drains a ring of fixed-size commands that software places in system memory. Software programs a ring base, a ring size code and head and tail pointers through a small register write port, and sets an enable bit. When software writes any of those registers, the block makes one processing attempt. If the ring is non-empty, it reads the 16-byte entry at the head over a single-outstanding memory request port, decodes its opcode, executes it and moves the head forward.

The only command with an effect is completion-wait. It stores an 8-byte payload carried in the entry to an 8-byte-aligned address, also carried in the entry, and then raises a sticky completion status bit. The invalidation commands and any unknown opcode are retired without touching memory. The updated head and two status bits are driven out continuously, so software can watch progress.

Top module: `cmd_ring_proc`

## Requirements
- R1: After reset the head is 0, the status output is 0, no memory request is driven, the base is 0 and the size code is 8, so the ring spans 4096 bytes.
- R2: Commands are processed only while the enable bit (bit 12 of a control write, select 0) is 1. Status bit 4 equals that enable bit.
- R3: Every register write arms exactly one processing attempt. An attempt handles at most one entry. When head equals tail, the attempt issues no memory access.
- R4: An entry is fetched as two 8-byte reads, at base+head and then at base+head+8. The opcode is bits 63:60 of the first word, which is the upper nibble of entry byte 7.
- R5: Opcode 1 (completion-wait) writes the entry's second word to the address in bits 51:3 of the first word, with bits 2:0 forced to 0. When that write is accepted, status bit 2 is set, and it stays set until reset.
- R6: Opcodes 2 to 5 (invalidations) and all other opcodes issue no memory write. They still advance the head.
- R7: After each entry the head advances by 16. It returns to 0 when it reaches 16 << size code bytes.
- R8: Head (select 2) and tail (select 3) writes keep only data bits 18:4. A base write (select 1) takes the base from bits 51:12 and the size code from bits 59:56.
- R9: At most one memory request is outstanding. While valid is high and ready is low, the request's address, direction and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 control, 1 base, 2 head, 3 tail |
| reg_wr_data | input | 64 | Register write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for a store, 0 for a read |
| mem_req_addr | output | ADDR_W | Byte address of the 8-byte access |
| mem_req_wdata | output | 64 | Store data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| head_o | output | PTR_W | Current head pointer |
| status_o | output | 8 | Bit 4 running, bit 2 completion-wait done |

## Verification
The bench targets the head wrap at the default 4096-byte ring and at a programmed 64-byte ring. A design that wraps at the wrong size reads outside the ring, or lands on a head value that no longer matches tail. It checks that one write triggers only one entry even when more are queued, since a free-running design would drain the ring at once. It also checks that an empty or disabled attempt issues no read, and that the completion store address is masked and aligned: a missing mask shows up as a wrong store address. The memory ready line toggles every cycle, so a request that changes while stalled is caught.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

    localparam int DATA_W       = 64;
    localparam int ENTRY_BYTES  = 16;
    localparam int DEF_ADDR_W   = 52;
    localparam int DEF_PTR_W    = 19;
    localparam int CODE_W       = 4;
    localparam int CODE_POS     = 56;
    localparam int BASE_LO      = 12;
    localparam int CTRL_EN_POS  = 12;
    localparam int STATUS_W     = 8;
    localparam int STAT_CW_DONE = 2;
    localparam int STAT_RUN     = 4;
    localparam logic [CODE_W-1:0] CODE_RESET = 4'd8;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_BASE = 2'd1,
        SEL_HEAD = 2'd2,
        SEL_TAIL = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        KIND_CWAIT,
        KIND_INVAL,
        KIND_UNKNOWN
    } cmd_kind_e;

    typedef struct packed {
        logic [3:0] opcode;
        cmd_kind_e  kind;
    } cmd_info_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_DECODE,
        ST_WR_REQ,
        ST_RETIRE
    } eng_state_e;

    function automatic cmd_kind_e classify(input logic [3:0] op);
        case (op)
            4'd1:                    return KIND_CWAIT;
            4'd2, 4'd3, 4'd4, 4'd5:  return KIND_INVAL;
            default:                 return KIND_UNKNOWN;
        endcase
    endfunction

endpackage

// File: rtl/cmdring_regs.sv
module cmdring_regs
    import cmdring_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int PTR_W  = DEF_PTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              adv_en,
    input  logic [PTR_W-1:0]  adv_head,
    output logic              enable,
    output logic [ADDR_W-1:0] base,
    output logic [CODE_W-1:0] code,
    output logic [PTR_W-1:0]  head,
    output logic [PTR_W-1:0]  tail,
    output logic              arm
);
    localparam int PTR_LO = 4;

    logic [PTR_W-1:0] ptr_masked;
    assign ptr_masked = {wr_data[PTR_W-1:PTR_LO], {PTR_LO{1'b0}}};
    assign arm = wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
            base   <= '0;
            code   <= CODE_RESET;
            head   <= '0;
            tail   <= '0;
        end else begin
            if (adv_en)
                head <= adv_head;
            if (wr_en) begin
                case (reg_sel_e'(wr_sel))
                    SEL_CTRL: enable <= wr_data[CTRL_EN_POS];
                    SEL_BASE: begin
                        base <= {wr_data[ADDR_W-1:BASE_LO], {BASE_LO{1'b0}}};
                        code <= wr_data[CODE_POS +: CODE_W];
                    end
                    SEL_HEAD: head <= ptr_masked;
                    default:  tail <= ptr_masked;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmdring_decode.sv
module cmdring_decode
    import cmdring_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic [DATA_W-1:0] word0,
    output cmd_info_t         info,
    output logic [ADDR_W-1:0] store_addr
);
    localparam int OP_POS = DATA_W - 4;

    always_comb begin
        info.opcode = word0[OP_POS +: 4];
        info.kind   = classify(word0[OP_POS +: 4]);
        store_addr  = {word0[ADDR_W-1:3], 3'b000};
    end
endmodule

// File: rtl/cmdring_engine.sv
module cmdring_engine
    import cmdring_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int PTR_W  = DEF_PTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [ADDR_W-1:0] base,
    input  logic [CODE_W-1:0] code,
    input  logic [PTR_W-1:0]  head,
    input  logic [PTR_W-1:0]  tail,
    input  logic              arm,
    input  cmd_info_t         info,
    input  logic [ADDR_W-1:0] store_addr,
    output logic [DATA_W-1:0] word0,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              adv_en,
    output logic [PTR_W-1:0]  adv_head,
    output logic              cw_done
);
    localparam int WIDE_W = PTR_W + 1;

    eng_state_e        state;
    logic              pending;
    logic              beat;
    logic [DATA_W-1:0] word1;
    logic [WIDE_W-1:0] ring_bytes;
    logic [WIDE_W-1:0] head_inc;
    logic [ADDR_W-1:0] fetch_addr;

    assign ring_bytes = WIDE_W'(ENTRY_BYTES) << code;
    assign head_inc   = {1'b0, head} + WIDE_W'(ENTRY_BYTES);
    assign adv_head   = (head_inc == ring_bytes) ? '0 : head_inc[PTR_W-1:0];
    assign adv_en     = (state == ST_RETIRE);
    assign fetch_addr = base + ADDR_W'(head) + ADDR_W'({beat, 3'b000});

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = fetch_addr;
        mem_req_wdata = word1;
        case (state)
            ST_RD_REQ: mem_req_valid = 1'b1;
            ST_WR_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = store_addr;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pending <= 1'b0;
            beat    <= 1'b0;
            word0   <= '0;
            word1   <= '0;
            cw_done <= 1'b0;
        end else begin
            if (arm)
                pending <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (pending) begin
                        if (!arm)
                            pending <= 1'b0;
                        if (enable && (head != tail)) begin
                            beat  <= 1'b0;
                            state <= ST_RD_REQ;
                        end
                    end
                end
                ST_RD_REQ: begin
                    if (mem_req_ready)
                        state <= ST_RD_WAIT;
                end
                ST_RD_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!beat) begin
                            word0 <= mem_rsp_data;
                            beat  <= 1'b1;
                            state <= ST_RD_REQ;
                        end else begin
                            word1 <= mem_rsp_data;
                            state <= ST_DECODE;
                        end
                    end
                end
                ST_DECODE: begin
                    state <= (info.kind == KIND_CWAIT) ? ST_WR_REQ : ST_RETIRE;
                end
                ST_WR_REQ: begin
                    if (mem_req_ready) begin
                        cw_done <= 1'b1;
                        state   <= ST_RETIRE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmd_ring_proc.sv
module cmd_ring_proc
    import cmdring_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int PTR_W  = DEF_PTR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr_en,
    input  logic [1:0]          reg_wr_sel,
    input  logic [DATA_W-1:0]   reg_wr_data,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic                mem_req_write,
    output logic [ADDR_W-1:0]   mem_req_addr,
    output logic [DATA_W-1:0]   mem_req_wdata,
    input  logic                mem_rsp_valid,
    input  logic [DATA_W-1:0]   mem_rsp_data,
    output logic [PTR_W-1:0]    head_o,
    output logic [STATUS_W-1:0] status_o
);
    logic              enable;
    logic [ADDR_W-1:0] base;
    logic [CODE_W-1:0] code;
    logic [PTR_W-1:0]  tail;
    logic              arm;
    logic              adv_en;
    logic [PTR_W-1:0]  adv_head;
    logic              cw_done;
    logic [DATA_W-1:0] word0;
    cmd_info_t         info;
    logic [ADDR_W-1:0] store_addr;

    cmdring_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
        .adv_en(adv_en), .adv_head(adv_head),
        .enable(enable), .base(base), .code(code),
        .head(head_o), .tail(tail), .arm(arm)
    );

    cmdring_decode #(.ADDR_W(ADDR_W)) u_dec (
        .word0(word0), .info(info), .store_addr(store_addr)
    );

    cmdring_engine #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_eng (
        .clk(clk), .rst(rst),
        .enable(enable), .base(base), .code(code),
        .head(head_o), .tail(tail), .arm(arm),
        .info(info), .store_addr(store_addr), .word0(word0),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .adv_en(adv_en), .adv_head(adv_head), .cw_done(cw_done)
    );

    always_comb begin
        status_o               = '0;
        status_o[STAT_RUN]     = enable;
        status_o[STAT_CW_DONE] = cw_done;
    end
endmodule

// File: rtl/cmdring_checker.sv
module cmdring_checker
    import cmdring_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int PTR_W  = DEF_PTR_W
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_wr_en,
    input logic [1:0]          reg_wr_sel,
    input logic                mem_req_valid,
    input logic                mem_req_ready,
    input logic                mem_req_write,
    input logic [ADDR_W-1:0]   mem_req_addr,
    input logic [DATA_W-1:0]   mem_req_wdata,
    input logic [PTR_W-1:0]    head_o,
    input logic [STATUS_W-1:0] status_o
);
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) &&
             $stable(mem_req_write) && $stable(mem_req_wdata)));

    p_req_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> status_o[STAT_RUN]);

    p_flag_after_store_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[STAT_CW_DONE]) |->
            $past(mem_req_valid && mem_req_ready && mem_req_write));

    p_head_step_r7: assert property (@(posedge clk) disable iff (rst)
        ((head_o != $past(head_o)) &&
         !$past(reg_wr_en && (reg_wr_sel == 2'(SEL_HEAD)))) |->
            ((head_o == $past(head_o) + PTR_W'(ENTRY_BYTES)) || (head_o == '0)));

    p_head_aligned_r8: assert property (@(posedge clk) disable iff (rst)
        head_o[3:0] == 4'd0);
endmodule

bind cmd_ring_proc cmdring_checker #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .head_o(head_o), .status_o(status_o)
);

// File: tb/cmd_ring_proc_test.sv
module cmd_ring_proc_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 52;
    localparam int PW = 19;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr_en = 1'b0;
    logic [1:0]    reg_wr_sel = 2'd0;
    logic [63:0]   reg_wr_data = '0;
    logic          mem_req_valid;
    logic          mem_req_ready;
    logic          mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [63:0]   mem_req_wdata;
    logic          mem_rsp_valid;
    logic [63:0]   mem_rsp_data;
    logic [PW-1:0] head_o;
    logic [7:0]    status_o;

    logic [63:0]   mem [256];
    int            rd_cnt, wr_cnt, hold_err;
    logic [AW-1:0] rd_addr_a, rd_addr_b, last_wr_addr;
    logic [63:0]   last_wr_data;
    logic          prev_hold;
    logic [AW-1:0] prev_addr;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_ring_proc uut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .head_o(head_o), .status_o(status_o)
    );

    // memory model: ready toggles every cycle, read data one cycle after acceptance
    always @(posedge clk) begin
        if (rst) begin
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            rd_cnt <= 0; wr_cnt <= 0; hold_err <= 0;
            rd_addr_a <= '0; rd_addr_b <= '0;
            last_wr_addr <= '0; last_wr_data <= '0;
            prev_hold <= 1'b0; prev_addr <= '0;
        end else begin
            mem_req_ready <= ~mem_req_ready;
            mem_rsp_valid <= 1'b0;
            if (prev_hold && (!mem_req_valid || mem_req_addr != prev_addr))
                hold_err <= hold_err + 1;
            prev_hold <= mem_req_valid && !mem_req_ready;
            prev_addr <= mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    wr_cnt       <= wr_cnt + 1;
                    last_wr_addr <= mem_req_addr;
                    last_wr_data <= mem_req_wdata;
                end else begin
                    rd_cnt        <= rd_cnt + 1;
                    rd_addr_a     <= rd_addr_b;
                    rd_addr_b     <= mem_req_addr;
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= mem[mem_req_addr[10:3]];
                end
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [63:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
        wait_cycles(40);
    endtask

    function automatic logic [63:0] op_word(input logic [3:0] op, input logic [59:0] rest);
        return {op, rest};
    endfunction

    task automatic t_reset;
        check("R1 head", 64'(head_o), 64'h0);
        check("R1 status", 64'(status_o), 64'h0);
        check("R1 no request", 64'(mem_req_valid), 64'h0);
    endtask

    task automatic t_default_ring;
        int r0;
        mem[8'hFE] = op_word(4'd2, 60'h0);
        mem[8'hFF] = 64'h0;
        reg_write(2'd2, 64'hFF0);
        reg_write(2'd3, 64'h0);
        check("R2 disabled no reads", 64'(rd_cnt), 64'h0);
        check("R2 run bit low", 64'(status_o[4]), 64'h0);
        r0 = rd_cnt;
        reg_write(2'd0, 64'h1000);
        check("R2 run bit high", 64'(status_o[4]), 64'h1);
        check("R1 default ring wraps at 4096", 64'(head_o), 64'h0);
        check("R4 two reads per entry", 64'(rd_cnt - r0), 64'h2);
        check("R6 invalidate no write", 64'(wr_cnt), 64'h0);
    endtask

    task automatic t_setup_small_ring;
        mem[0] = op_word(4'd1, 60'h0F0_0000_0000_1405);
        mem[1] = 64'hCAFE_F00D_1234_5678;
        mem[2] = op_word(4'd3, 60'h0);
        mem[3] = 64'h0;
        mem[4] = op_word(4'd9, 60'h0);
        mem[5] = 64'h0;
        mem[6] = op_word(4'd5, 60'h0);
        mem[7] = 64'h0;
        reg_write(2'd0, 64'h0);
        reg_write(2'd1, 64'h0200_0000_0000_1ABC);
        reg_write(2'd2, 64'h0);
        reg_write(2'd3, 64'h0);
        reg_write(2'd0, 64'h1000);
    endtask

    task automatic t_cwait;
        check("R5 flag clear before", 64'(status_o[2]), 64'h0);
        reg_write(2'd3, 64'h10);
        check("R4 first read addr", 64'(rd_addr_a), 64'h1000);
        check("R4 second read addr", 64'(rd_addr_b), 64'h1008);
        check("R5 store addr masked", 64'(last_wr_addr), 64'h1400);
        check("R5 store data", last_wr_data, 64'hCAFE_F00D_1234_5678);
        check("R5 flag set", 64'(status_o[2]), 64'h1);
        check("R7 head +16", 64'(head_o), 64'h10);
    endtask

    task automatic t_inval;
        int w0;
        w0 = wr_cnt;
        reg_write(2'd3, 64'h20);
        check("R6 invalidate no write", 64'(wr_cnt - w0), 64'h0);
        check("R6 head advanced", 64'(head_o), 64'h20);
    endtask

    task automatic t_one_per_trigger;
        int w0;
        w0 = wr_cnt;
        reg_write(2'd3, 64'h0);
        wait_cycles(60);
        check("R3 one entry per trigger", 64'(head_o), 64'h30);
        check("R6 unknown opcode no write", 64'(wr_cnt - w0), 64'h0);
        reg_write(2'd0, 64'h1000);
        check("R7 wrap at 64-byte ring", 64'(head_o), 64'h0);
        check("R5 flag sticky", 64'(status_o[2]), 64'h1);
    endtask

    task automatic t_empty;
        int r0;
        r0 = rd_cnt;
        reg_write(2'd0, 64'h1000);
        check("R3 empty ring no fetch", 64'(rd_cnt - r0), 64'h0);
        check("R3 empty head unchanged", 64'(head_o), 64'h0);
    endtask

    task automatic t_mask;
        int r0;
        reg_write(2'd0, 64'h0);
        reg_write(2'd2, 64'h0010_0037);
        check("R8 head masked", 64'(head_o), 64'h30);
        reg_write(2'd3, 64'h0008_003F);
        r0 = rd_cnt;
        reg_write(2'd0, 64'h1000);
        check("R8 tail masked equals head", 64'(rd_cnt - r0), 64'h0);
        check("R9 request stable while stalled", 64'(hold_err), 64'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        wait_cycles(4);
        rst = 1'b0;
        wait_cycles(2);
        t_reset();
        t_default_ring();
        t_setup_small_ring();
        t_cwait();
        t_inval();
        t_one_per_trigger();
        t_empty();
        t_mask();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule